// File: doc/BRIEF.md
# Dual-Channel I2C Wiper Register Slave

This block is the digital side of a two-channel digital potentiometer. It sits on an I2C-compatible two-wire bus as a slave. It holds two 8-bit wiper codes and one shutdown flag, and it drives analog switches further down the chip. SCL and SDA are oversampled on a system clock that runs much faster than SCL. The slave pulls SDA low through an open-drain enable and never drives it high.

A write transaction has three parts: the address byte, then an instruction byte, then any number of data bytes. The instruction byte picks the target channel from its top bit and sets or clears shutdown from the next bit. Each data byte that follows goes into the chosen channel until the master ends the transaction. A read transaction returns the code of the channel picked by the most recent instruction. No register pointer is sent during a read. The master may read that same byte repeatedly, acknowledging each one, and ends with a NACK. Shutdown only raises the flag that opens the A terminal and ties the wiper to B. The stored codes stay as they are.

Top module: `dual_wiper_i2c_slave`

## Requirements
- R1: After reset both wiper codes are 0x80, shutdown is 0, channel 1 is selected and SDA is released.
- R2: The 7-bit slave address is 0101 1 followed by two low bits. The address byte is sent MSB first, and its bit 0 is the R/W bit (1 = read). When the pin-address mode input is 1, the two low bits are {addr_pin_i[1], addr_pin_i[0]}. When it is 0, both low bits are 1. On a match the slave pulls SDA low during the ninth clock.
- R3: An address that does not match gets no acknowledge. After it, the slave drives nothing and ignores every data byte until the next start.
- R4: In a write, the byte after the address is the instruction. Bit 7 selects the channel (0 = channel 1, 1 = channel 2). Bit 6 sets shutdown. Bits 5..0 are ignored. The instruction byte is acknowledged.
- R5: Every data byte after the instruction is acknowledged and written into the selected channel's wiper code. Further bytes keep writing the same channel until a stop.
- R6: While shutdown is set, shutdown_o is 1, the wiper codes keep their values and data writes are still accepted. When shutdown is cleared, the stored codes remain unchanged.
- R7: In a read, the data byte follows the address acknowledge directly, MSB first. It is the code of the channel selected by the last instruction. A master ACK sends the byte again, and a master NACK releases SDA.
- R8: A start or stop in the middle of a byte abandons that byte. A partial byte is never written.
- R9: The channel selection and the shutdown state last across transactions.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| pin_addr_mode_i | input | 1 | 1: low address bits come from addr_pin_i; 0: they are 11 |
| addr_pin_i | input | 2 | Board-strapped low address bits |
| wiper0_o | output | 8 | Channel 1 wiper code |
| wiper1_o | output | 8 | Channel 2 wiper code |
| shutdown_o | output | 1 | A open, wiper tied to B |

## Verification
Every result is due on the third rising clock edge after the SCL or SDA edge that causes it. Two of those edges go to the synchronizer and one to the state register. This covers the acknowledge and data drive on SDA, a wiper write on the eighth falling SCL edge of a data byte, and a shutdown change on the eighth falling edge of an instruction. The bench changes SCL and SDA only on falling clock edges. Its behavioural model changes its expected values at the same moment and passes them through a three-stage delay. The outputs are compared against that delayed model on every falling clock edge. Bus levels, such as acknowledges and read bits, are sampled eight clocks into the SCL high phase, well clear of that latency.

// File: rtl/dwi_pkg.sv
package dwi_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_CH = 2;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int CH_BIT = BYTE_W - 1;
  localparam int SD_BIT = BYTE_W - 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INSTR,
    ST_WDATA,
    ST_SACK,
    ST_RDATA,
    ST_MACK
  } phase_e;
endpackage

// File: rtl/dwi_bus_front.sv
module dwi_bus_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_q, sda_q;

  // idle bus is high, so reset to 1 to avoid a false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_sr[SYNC_STAGES-1];
      sda_q  <= sda_sr[SYNC_STAGES-1];
    end
  end

  assign scl_lvl_o  = scl_sr[SYNC_STAGES-1];
  assign sda_lvl_o  = sda_sr[SYNC_STAGES-1];
  assign scl_rise_o = scl_lvl_o & ~scl_q;
  assign scl_fall_o = ~scl_lvl_o & scl_q;
  assign start_o    = scl_lvl_o & scl_q & sda_q & ~sda_lvl_o;
  assign stop_o     = scl_lvl_o & scl_q & ~sda_q & sda_lvl_o;
endmodule

// File: rtl/dwi_protocol.sv
module dwi_protocol
  import dwi_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b01011,
  parameter logic [1:0] FIXED_LOW   = 2'b11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              pin_addr_mode_i,
  input  logic [1:0]        addr_pin_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              instr_we_o,
  output logic              data_we_o,
  output logic [BYTE_W-1:0] wr_byte_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  phase_e            state_q, ack_next_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              sda_oe_q, mack_q;
  logic [6:0]        own_addr;
  logic              byte_done, bus_evt;

  assign own_addr  = {ADDR_PREFIX, pin_addr_mode_i ? addr_pin_i : FIXED_LOW};
  assign bus_evt   = start_i | stop_i;
  assign byte_done = scl_fall_i && (bit_cnt_q == FULL) && !bus_evt;

  assign instr_we_o = byte_done && (state_q == ST_INSTR);
  assign data_we_o  = byte_done && (state_q == ST_WDATA);
  assign wr_byte_o  = shreg_q;
  assign sda_oe_o   = sda_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ack_next_q <= ST_IDLE;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      sda_oe_q   <= 1'b0;
      mack_q     <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      sda_oe_q  <= 1'b0;
    end else if (stop_i) begin
      state_q  <= ST_IDLE;
      sda_oe_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_INSTR, ST_WDATA: begin
          if (scl_rise_i && bit_cnt_q != FULL) begin
            shreg_q   <= {shreg_q[BYTE_W-2:0], sda_lvl_i};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (byte_done) begin
            if (state_q != ST_ADDR) begin
              sda_oe_q   <= 1'b1;
              state_q    <= ST_SACK;
              ack_next_q <= ST_WDATA;
            end else if (shreg_q[BYTE_W-1:1] == own_addr) begin
              sda_oe_q   <= 1'b1;
              state_q    <= ST_SACK;
              ack_next_q <= shreg_q[0] ? ST_RDATA : ST_INSTR;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_SACK: begin
          if (scl_fall_i) begin
            bit_cnt_q <= '0;
            state_q   <= ack_next_q;
            if (ack_next_q == ST_RDATA) begin
              shreg_q  <= rd_data_i;
              sda_oe_q <= ~rd_data_i[BYTE_W-1];
            end else begin
              sda_oe_q <= 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise_i) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (scl_fall_i) begin
            if (bit_cnt_q == FULL) begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_MACK;
            end else if (bit_cnt_q != '0) begin
              shreg_q  <= {shreg_q[BYTE_W-2:0], 1'b0};
              sda_oe_q <= ~shreg_q[BYTE_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_lvl_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              shreg_q   <= rd_data_i;
              sda_oe_q  <= ~rd_data_i[BYTE_W-1];
              bit_cnt_q <= '0;
              state_q   <= ST_RDATA;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dwi_wiper_bank.sv
module dwi_wiper_bank
  import dwi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_we_i,
  input  logic              data_we_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [BYTE_W-1:0] code_o [NUM_CH],
  output logic              shutdown_o
);
  localparam logic [BYTE_W-1:0] MIDSCALE = BYTE_W'(1) << (BYTE_W - 1);

  logic                      sel_q, sd_q;
  logic [BYTE_W-1:0]         code_q [NUM_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
      sd_q  <= 1'b0;
    end else if (instr_we_i) begin
      sel_q <= wr_byte_i[CH_BIT];
      sd_q  <= wr_byte_i[SD_BIT];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) code_q[c] <= MIDSCALE;
      else if (data_we_i && sel_q == 1'(c)) code_q[c] <= wr_byte_i;
    end
    assign code_o[c] = code_q[c];
  end

  assign rd_data_o  = code_q[sel_q];
  assign shutdown_o = sd_q;
endmodule

// File: rtl/dual_wiper_i2c_slave.sv
module dual_wiper_i2c_slave
  import dwi_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_PREFIX = 5'b01011,
  parameter logic [1:0] FIXED_LOW   = 2'b11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              pin_addr_mode_i,
  input  logic [1:0]        addr_pin_i,
  output logic [BYTE_W-1:0] wiper0_o,
  output logic [BYTE_W-1:0] wiper1_o,
  output logic              shutdown_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic instr_we, data_we;
  logic [BYTE_W-1:0] wr_byte, rd_data;
  logic [BYTE_W-1:0] codes [NUM_CH];

  dwi_bus_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_lvl_o(scl_lvl), .sda_lvl_o(sda_lvl),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  dwi_protocol #(.ADDR_PREFIX(ADDR_PREFIX), .FIXED_LOW(FIXED_LOW)) u_proto (
    .clk_i, .rst_ni,
    .sda_lvl_i(sda_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .pin_addr_mode_i, .addr_pin_i,
    .rd_data_i(rd_data),
    .sda_oe_o,
    .instr_we_o(instr_we), .data_we_o(data_we), .wr_byte_o(wr_byte)
  );

  dwi_wiper_bank u_bank (
    .clk_i, .rst_ni,
    .instr_we_i(instr_we), .data_we_i(data_we), .wr_byte_i(wr_byte),
    .rd_data_o(rd_data), .code_o(codes), .shutdown_o
  );

  assign wiper0_o = codes[0];
  assign wiper1_o = codes[1];
endmodule

// File: rtl/dwi_checker.sv
module dwi_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_lvl_i,
  input logic       sda_oe_i,
  input logic       instr_we_i,
  input logic       data_we_i,
  input logic [7:0] wiper0_i,
  input logic [7:0] wiper1_i,
  input logic       shutdown_i
);
  // R10
  sda_drive_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_i != $past(sda_oe_i)) |-> !scl_lvl_i);

  // R5
  wiper0_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wiper0_i) |-> $past(data_we_i));

  // R5
  wiper1_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wiper1_i) |-> $past(data_we_i));

  // R6
  shutdown_keeps_codes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(shutdown_i) |-> ($stable(wiper0_i) && $stable(wiper1_i)));

  // R4
  one_write_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({instr_we_i, data_we_i}));
endmodule

bind dual_wiper_i2c_slave dwi_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_lvl_i(scl_lvl), .sda_oe_i(sda_oe_o),
  .instr_we_i(instr_we), .data_we_i(data_we),
  .wiper0_i(wiper0_o), .wiper1_i(wiper1_o), .shutdown_i(shutdown_o)
);

// File: tb/tb_dual_wiper_i2c_slave.sv
module tb_dual_wiper_i2c_slave;
  localparam int H = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_drv = 1'b1, sda_drv = 1'b1;
  logic       pin_mode = 1'b0;
  logic [1:0] pins = 2'b00;
  logic       sda_oe, sd;
  logic [7:0] w0, w1;
  wire        sda_line = sda_drv & ~sda_oe;

  dual_wiper_i2c_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .pin_addr_mode_i(pin_mode), .addr_pin_i(pins),
    .wiper0_o(w0), .wiper1_o(w1), .shutdown_o(sd)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit cmp_en = 1'b0, done = 1'b0;

  // behavioural model state
  logic [7:0] exp_w [2];
  logic       exp_sel = 1'b0, exp_sd = 1'b0, exp_oe = 1'b0;
  logic [7:0] q0 [3], q1 [3];
  logic       qs [3], qo [3];

  initial begin
    exp_w[0] = 8'h80;
    exp_w[1] = 8'h80;
  end

  // three-clock latency: two synchronizer stages plus the state register
  always @(posedge clk) begin
    q0[0] <= exp_w[0]; q0[1] <= q0[0]; q0[2] <= q0[1];
    q1[0] <= exp_w[1]; q1[1] <= q1[0]; q1[2] <= q1[1];
    qs[0] <= exp_sd;   qs[1] <= qs[0]; qs[2] <= qs[1];
    qo[0] <= exp_oe;   qo[1] <= qo[0]; qo[2] <= qo[1];
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h t=%0t", tag, what, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(w0 == q0[2], "R5", "wiper0 per-clock", w0, q0[2]);
      chk(w1 == q1[2], "R5", "wiper1 per-clock", w1, q1[2]);
      chk(sd == qs[2], "R6", "shutdown per-clock", sd, qs[2]);
      chk(sda_oe == qo[2], "R10", "sda drive per-clock", sda_oe, qo[2]);
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      errors++;
      $display("FAIL watchdog all actual=timeout expected=finished");
      summary();
      $finish;
    end
  end

  task automatic hw();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; hw();
    scl_drv = 1'b1; hw();
    sda_drv = 1'b0; hw();
    scl_drv = 1'b0; hw();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; hw();
    scl_drv = 1'b1; hw();
    sda_drv = 1'b1; hw();
  endtask

  // kind: 0 none, 1 instruction, 2 data
  task automatic write_byte(input logic [7:0] b, input bit acks, input logic nxt_oe,
                            input int kind, input string tag);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; hw();
      scl_drv = 1'b1; hw();
      if (i == 0) begin
        exp_oe = acks;
        if (acks && kind == 1) begin
          exp_sel = b[7];
          exp_sd  = b[6];
        end else if (acks && kind == 2) begin
          exp_w[exp_sel] = b;
        end
      end
      scl_drv = 1'b0; hw();
    end
    sda_drv = 1'b1; hw();
    scl_drv = 1'b1; hw();
    chk((sda_line == 1'b0) == acks, tag, "acknowledge", !sda_line, acks);
    exp_oe = acks ? nxt_oe : 1'b0;
    scl_drv = 1'b0; hw();
  endtask

  task automatic partial_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_drv = b[7-i]; hw();
      scl_drv = 1'b1; hw();
      scl_drv = 1'b0; hw();
    end
  endtask

  task automatic read_byte(input logic [7:0] expv, input bit mack, input string tag);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = 1'b1; hw();
      scl_drv = 1'b1; hw();
      chk(sda_line == expv[i], tag, "read bit", sda_line, expv[i]);
      exp_oe = (i > 0) ? !expv[i-1] : 1'b0;
      scl_drv = 1'b0; hw();
    end
    sda_drv = !mack; hw();
    scl_drv = 1'b1; hw();
    exp_oe = mack ? !expv[7] : 1'b0;
    scl_drv = 1'b0; hw();
    sda_drv = 1'b1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;
    // R1 reset state
    chk(w0 == 8'h80, "R1", "wiper0 reset", w0, 8'h80);
    chk(w1 == 8'h80, "R1", "wiper1 reset", w1, 8'h80);
    chk(sd == 1'b0, "R1", "shutdown reset", sd, 0);
    chk(sda_oe == 1'b0, "R1", "sda released", sda_oe, 0);

    // R1: read after reset returns channel 1 midscale
    bus_start();
    write_byte(8'h5F, 1'b1, !exp_w[exp_sel][7], 0, "R2");
    read_byte(8'h80, 1'b0, "R1");
    bus_stop();

    // R5: fixed address, channel 1, repeated data bytes
    bus_start();
    write_byte(8'h5E, 1'b1, 1'b0, 0, "R2");
    write_byte(8'h00, 1'b1, 1'b0, 1, "R4");
    write_byte(8'h3C, 1'b1, 1'b0, 2, "R5");
    write_byte(8'hA5, 1'b1, 1'b0, 2, "R5");
    bus_stop();
    chk(w0 == 8'hA5, "R5", "wiper0 after repeat", w0, 8'hA5);
    chk(w1 == 8'h80, "R5", "wiper1 untouched", w1, 8'h80);

    // R4: channel 2 with don't-care low bits set
    bus_start();
    write_byte(8'h5E, 1'b1, 1'b0, 0, "R2");
    write_byte(8'h95, 1'b1, 1'b0, 1, "R4");
    write_byte(8'h11, 1'b1, 1'b0, 2, "R4");
    bus_stop();
    chk(w1 == 8'h11 && sd == 1'b0, "R4", "channel 2 written, low bits ignored", w1, 8'h11);

    // R7 R9: read in a later transaction returns channel 2, repeated
    bus_start();
    write_byte(8'h5F, 1'b1, !exp_w[exp_sel][7], 0, "R2");
    read_byte(8'h11, 1'b1, "R7");
    read_byte(8'h11, 1'b0, "R9");
    chk(sda_oe == 1'b0, "R7", "released after nack", sda_oe, 0);
    bus_stop();

    // R6: shutdown, write while shut down, then clear
    bus_start();
    write_byte(8'h5E, 1'b1, 1'b0, 0, "R2");
    write_byte(8'hC0, 1'b1, 1'b0, 1, "R6");
    write_byte(8'h77, 1'b1, 1'b0, 2, "R6");
    bus_stop();
    chk(sd == 1'b1, "R6", "shutdown set", sd, 1);
    chk(w1 == 8'h77 && w0 == 8'hA5, "R6", "codes kept in shutdown", w1, 8'h77);
    bus_start();
    write_byte(8'h5F, 1'b1, !exp_w[exp_sel][7], 0, "R2");
    read_byte(8'h77, 1'b0, "R9");
    bus_stop();
    chk(sd == 1'b1, "R9", "shutdown persists", sd, 1);
    bus_start();
    write_byte(8'h5E, 1'b1, 1'b0, 0, "R2");
    write_byte(8'h80, 1'b1, 1'b0, 1, "R6");
    bus_stop();
    chk(sd == 1'b0 && w1 == 8'h77, "R6", "shutdown cleared, code kept", w1, 8'h77);

    // R3: wrong address in fixed mode, then data is ignored
    bus_start();
    write_byte(8'h5A, 1'b0, 1'b0, 0, "R3");
    write_byte(8'h00, 1'b0, 1'b0, 0, "R3");
    bus_stop();
    chk(w0 == 8'hA5 && w1 == 8'h77, "R3", "no write after mismatch", w1, 8'h77);

    // R2: pin-address mode with pins 01
    pin_mode = 1'b1;
    pins = 2'b01;
    bus_start();
    write_byte(8'h5E, 1'b0, 1'b0, 0, "R2");
    bus_stop();
    bus_start();
    write_byte(8'h5A, 1'b1, 1'b0, 0, "R2");
    write_byte(8'h00, 1'b1, 1'b0, 1, "R4");
    write_byte(8'h42, 1'b1, 1'b0, 2, "R2");
    bus_stop();
    chk(w0 == 8'h42, "R2", "pin-mode write", w0, 8'h42);

    // R8: stop inside a data byte
    bus_start();
    write_byte(8'h5A, 1'b1, 1'b0, 0, "R2");
    write_byte(8'h80, 1'b1, 1'b0, 1, "R4");
    partial_bits(8'hFF, 5);
    bus_stop();
    chk(w1 == 8'h77, "R8", "partial byte after stop", w1, 8'h77);

    // R8: repeated start inside a data byte, then instruction-only write
    bus_start();
    write_byte(8'h5A, 1'b1, 1'b0, 0, "R2");
    write_byte(8'h00, 1'b1, 1'b0, 1, "R4");
    partial_bits(8'h0F, 3);
    bus_start();
    write_byte(8'h5A, 1'b1, 1'b0, 0, "R2");
    write_byte(8'h00, 1'b1, 1'b0, 1, "R4");
    bus_stop();
    chk(w0 == 8'h42, "R8", "partial byte after restart", w0, 8'h42);
    bus_start();
    write_byte(8'h5B, 1'b1, !exp_w[exp_sel][7], 0, "R2");
    read_byte(8'h42, 1'b0, "R7");
    bus_stop();

    repeat (10) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule